// File: doc/BRIEF.md
# Page Translation Cache

This block keeps the most recently used linear-to-physical page translations so that most memory accesses can skip the page table walk. A requester presents a 20-bit linear page number. In the same cycle it gets a hit flag and, on a hit, the 20-bit physical frame number. Each entry maps one 4 KB page. The page number is the upper 20 bits of a 32-bit linear address.

On a miss, an external walker reads the tables and then writes the result through the fill port. That port either updates an entry already holding the page or takes a free or least recently used slot. A single flush input clears every entry at once. System software drives it whenever the table base register is rewritten or any directory or table entry changes. All 32 entries are searched in parallel. The block keeps an age ordering that ranks the entries by recency of use.

Top module: `tlb_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses.
- R2: With `lkp_valid_i` high, `lkp_hit_o` and `lkp_pfn_o` respond combinationally in the same cycle. On a hit they give the stored frame number. On a miss `lkp_pfn_o` is zero.
- R3: While `lkp_valid_i` is low, `lkp_hit_o` stays low whatever the page number.
- R4: When `fill_valid_i` is high and `flush_i` is low, the translation is installed at the clock edge and can be looked up from the next cycle.
- R5: A fill for a page number already held rewrites that entry's frame number in place. No page number ever matches more than one entry.
- R6: While any entry is invalid, a fill of a new page number lands in an invalid entry and evicts nothing.
- R7: When all entries are valid, a fill of a new page number replaces the least recently used entry. A lookup hit and a fill each make their entry the most recently used. When a fill and a lookup hit occur in the same cycle, only the fill's entry is promoted.
- R8: A high `flush_i` invalidates all entries at the clock edge, so every lookup in the next cycle misses.
- R9: When `flush_i` and `fill_valid_i` are high in the same cycle, the flush wins and the fill is discarded.
- R10: The block holds 32 distinct translations at once. Filling 32 distinct pages after a flush leaves all 32 retrievable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | 20 | Linear page number to translate |
| lkp_hit_o | output | 1 | Translation present (combinational) |
| lkp_pfn_o | output | 20 | Physical frame number on hit, zero otherwise |
| fill_valid_i | input | 1 | Install a translation at the next edge |
| fill_vpn_i | input | 20 | Linear page number being installed |
| fill_pfn_i | input | 20 | Physical frame number being installed |
| flush_i | input | 1 | Invalidate all entries |

## Verification
The bound checker checks the following on every cycle:
- No page number ever matches two entries.
- A lookup that is not requested never hits.
- An accepted fill lands at the chosen slot with the right tag.
- A flush leaves the valid vector empty.
- Free slots are used before any eviction.
- The evicted slot carries the oldest age.
- A promoted entry takes age zero.

Some behaviour cannot be seen from any single cycle and needs the bench's scenarios. This covers whether the age ordering really tracks use across long mixes of hits and fills, whether the stored frame numbers survive later writes, and whether in-place updates and flush priority show the correct data at the lookup port. The bench covers these with a vector table, directed eviction sequences and a long pseudo-random run compared against a recency-list model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned TLB_ENTRIES = 32;
  localparam int unsigned TLB_VPN_W   = 20;
  localparam int unsigned TLB_PFN_W   = 20;
endpackage

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 20,
  parameter int unsigned PW = 20,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic                  wr_en_i,
  input  logic [IW-1:0]         wr_idx_i,
  input  logic [VW-1:0]         wr_tag_i,
  input  logic [PW-1:0]         wr_data_i,
  output logic [N-1:0]          valid_o,
  output logic [N-1:0][VW-1:0]  tag_o,
  output logic [N-1:0][PW-1:0]  data_o
);
  logic [N-1:0]         valid_q;
  logic [N-1:0][VW-1:0] tag_q;
  logic [N-1:0][PW-1:0] data_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IW'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g] <= 1'b0;
        tag_q[g]   <= '0;
        data_q[g]  <= '0;
      end else if (flush_i) begin
        valid_q[g] <= 1'b0;
      end else if (sel) begin
        valid_q[g] <= 1'b1;
        tag_q[g]   <= wr_tag_i;
        data_q[g]  <= wr_data_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;
endmodule

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = 20,
  parameter int unsigned PW = 20,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]          valid_i,
  input  logic [N-1:0][VW-1:0]  tag_i,
  input  logic [N-1:0][PW-1:0]  data_i,
  input  logic [VW-1:0]         key_i,
  output logic [N-1:0]          match_o,
  output logic                  hit_o,
  output logic [IW-1:0]         idx_o,
  output logic [PW-1:0]         data_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == key_i);
  end

  assign hit_o = |match_o;

  // AND-OR select; relies on one-hot match
  always_comb begin
    idx_o  = '0;
    data_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) begin
        idx_o  = idx_o | IW'(i);
        data_o = data_o | data_i[i];
      end
    end
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int unsigned N  = 32,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 touch_en_i,
  input  logic [IW-1:0]        touch_idx_i,
  input  logic [N-1:0]         valid_i,
  output logic [IW-1:0]        victim_o,
  output logic [N-1:0][IW-1:0] age_o
);
  // ages form a permutation of 0..N-1; 0 is most recent
  logic [N-1:0][IW-1:0] age_q;
  logic [IW-1:0]        touch_age;

  assign touch_age = age_q[touch_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[g] <= IW'(g);
      end else if (touch_en_i) begin
        if (touch_idx_i == IW'(g))  age_q[g] <= '0;
        else if (age_q[g] < touch_age) age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  logic          any_free;
  logic [IW-1:0] free_idx;
  logic [IW-1:0] old_idx;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid_i[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (age_q[i] == IW'(N - 1)) old_idx = IW'(i);
    end
  end

  assign victim_o = any_free ? free_idx : old_idx;
  assign age_o    = age_q;
endmodule

// File: rtl/tlb_cache.sv
module tlb_cache
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES = TLB_ENTRIES,
  parameter int unsigned VPN_W   = TLB_VPN_W,
  parameter int unsigned PFN_W   = TLB_PFN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_valid_i,
  input  logic [VPN_W-1:0] lkp_vpn_i,
  output logic             lkp_hit_o,
  output logic [PFN_W-1:0] lkp_pfn_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PFN_W-1:0] fill_pfn_i,
  input  logic             flush_i
);
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  data_q;
  logic [ENTRIES-1:0][IW-1:0]     age_q;

  // port 0: lookup, port 1: fill probe
  logic [1:0][ENTRIES-1:0] port_match;
  logic [1:0]              port_hit;
  logic [1:0][IW-1:0]      port_idx;
  logic [1:0][PFN_W-1:0]   port_data;
  logic [1:0][VPN_W-1:0]   port_key;

  assign port_key[0] = lkp_vpn_i;
  assign port_key[1] = fill_vpn_i;

  for (genvar p = 0; p < 2; p++) begin : g_port
    tlb_match #(.N(ENTRIES), .VW(VPN_W), .PW(PFN_W)) u_match (
      .valid_i (valid_q),
      .tag_i   (tag_q),
      .data_i  (data_q),
      .key_i   (port_key[p]),
      .match_o (port_match[p]),
      .hit_o   (port_hit[p]),
      .idx_o   (port_idx[p]),
      .data_o  (port_data[p])
    );
  end

  logic [ENTRIES-1:0] lkp_match_oh;
  logic               fill_present;
  logic               fill_take;
  logic [IW-1:0]      victim_idx;
  logic [IW-1:0]      fill_idx;
  logic               touch_en;
  logic [IW-1:0]      touch_idx;

  assign lkp_match_oh = port_match[0];
  assign lkp_hit_o    = lkp_valid_i && port_hit[0];
  assign lkp_pfn_o    = lkp_valid_i ? port_data[0] : '0;

  assign fill_present = port_hit[1];
  assign fill_take    = fill_valid_i && !flush_i;
  assign fill_idx     = fill_present ? port_idx[1] : victim_idx;

  // fill wins recency when both occur
  assign touch_en  = fill_take || lkp_hit_o;
  assign touch_idx = fill_take ? fill_idx : port_idx[0];

  tlb_store #(.N(ENTRIES), .VW(VPN_W), .PW(PFN_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush_i),
    .wr_en_i   (fill_take),
    .wr_idx_i  (fill_idx),
    .wr_tag_i  (fill_vpn_i),
    .wr_data_i (fill_pfn_i),
    .valid_o   (valid_q),
    .tag_o     (tag_q),
    .data_o    (data_q)
  );

  tlb_lru #(.N(ENTRIES)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .valid_i     (valid_q),
    .victim_o    (victim_idx),
    .age_o       (age_q)
  );
endmodule

// File: rtl/tlb_cache_chk.sv
module tlb_cache_chk #(
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned VPN_W   = 20,
  localparam int unsigned IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           lkp_valid_i,
  input logic                           lkp_hit_o,
  input logic                           fill_valid_i,
  input logic [VPN_W-1:0]               fill_vpn_i,
  input logic                           flush_i,
  input logic [ENTRIES-1:0]             lkp_match_oh,
  input logic [ENTRIES-1:0]             valid_q,
  input logic [ENTRIES-1:0][VPN_W-1:0]  tag_q,
  input logic [IW-1:0]                  fill_idx,
  input logic                           fill_present,
  input logic                           touch_en,
  input logic [IW-1:0]                  touch_idx,
  input logic [ENTRIES-1:0][IW-1:0]     age_q
);
  AST_IDLE_NO_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |-> !lkp_hit_o); // R3

  AST_UNIQUE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lkp_match_oh)); // R5

  AST_FILL_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i) |=>
      (valid_q[$past(fill_idx)] && tag_q[$past(fill_idx)] == $past(fill_vpn_i))); // R4

  AST_FREE_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && !fill_present && !(&valid_q)) |-> !valid_q[fill_idx]); // R6

  AST_EVICT_OLDEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !flush_i && !fill_present && (&valid_q))
      |-> (age_q[fill_idx] == IW'(ENTRIES - 1))); // R7

  AST_PROMOTE_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_en |=> (age_q[$past(touch_idx)] == '0)); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0)); // R8
endmodule

bind tlb_cache tlb_cache_chk #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_hit_o    (lkp_hit_o),
  .fill_valid_i (fill_valid_i),
  .fill_vpn_i   (fill_vpn_i),
  .flush_i      (flush_i),
  .lkp_match_oh (lkp_match_oh),
  .valid_q      (valid_q),
  .tag_q        (tag_q),
  .fill_idx     (fill_idx),
  .fill_present (fill_present),
  .touch_en     (touch_en),
  .touch_idx    (touch_idx),
  .age_q        (age_q)
);

// File: tb/tlb_cache_test.sv
module tlb_cache_test;
  localparam int N = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid_i = 1'b0;
  logic [19:0] lkp_vpn_i = '0;
  logic        lkp_hit_o;
  logic [19:0] lkp_pfn_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_pfn_i = '0;
  logic        flush_i = 1'b0;

  always #5 clk_i = ~clk_i;

  tlb_cache uut (
    .clk_i, .rst_ni, .lkp_valid_i, .lkp_vpn_i, .lkp_hit_o, .lkp_pfn_o,
    .fill_valid_i, .fill_vpn_i, .fill_pfn_i, .flush_i
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input logic [20:0] act,
                       input logic [20:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // recency model: index 0 is most recent
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  int          m_cnt = 0;

  function automatic int m_find(input logic [19:0] v);
    for (int i = 0; i < m_cnt; i++) if (m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic m_promote(input int k);
    logic [19:0] v, p;
    v = m_vpn[k]; p = m_pfn[k];
    for (int i = k; i > 0; i--) begin
      m_vpn[i] = m_vpn[i-1]; m_pfn[i] = m_pfn[i-1];
    end
    m_vpn[0] = v; m_pfn[0] = p;
  endtask

  task automatic m_fill(input logic [19:0] v, input logic [19:0] p);
    int k;
    k = m_find(v);
    if (k >= 0) begin
      m_pfn[k] = p;
      m_promote(k);
    end else begin
      if (m_cnt < N) m_cnt++;
      m_vpn[m_cnt-1] = v;
      m_pfn[m_cnt-1] = p;
      m_promote(m_cnt - 1);
    end
  endtask

  // single-cycle operations, inputs changed at falling edge
  task automatic op_idle();
    @(negedge clk_i);
    lkp_valid_i = 1'b0; fill_valid_i = 1'b0; flush_i = 1'b0;
  endtask

  task automatic op_fill(input logic [19:0] v, input logic [19:0] p);
    @(negedge clk_i);
    lkp_valid_i = 1'b0; flush_i = 1'b0;
    fill_valid_i = 1'b1; fill_vpn_i = v; fill_pfn_i = p;
    m_fill(v, p);
  endtask

  task automatic op_flush();
    @(negedge clk_i);
    lkp_valid_i = 1'b0; fill_valid_i = 1'b0; flush_i = 1'b1;
    m_cnt = 0;
  endtask

  task automatic op_look(input logic [19:0] v, input string req);
    int k;
    @(negedge clk_i);
    fill_valid_i = 1'b0; flush_i = 1'b0;
    lkp_valid_i = 1'b1; lkp_vpn_i = v;
    #2;
    k = m_find(v);
    if (k >= 0) begin
      check(lkp_hit_o && lkp_pfn_o == m_pfn[k], req,
            {lkp_hit_o, lkp_pfn_o}, {1'b1, m_pfn[k]});
      m_promote(k);
    end else begin
      check(!lkp_hit_o && lkp_pfn_o == '0, req,
            {lkp_hit_o, lkp_pfn_o}, 21'h0);
    end
  endtask

  // ops: 0 lookup, 1 fill, 2 flush, 3 lookup with request low
  typedef struct packed {
    logic [1:0]  op;
    logic [19:0] vpn;
    logic [19:0] pfn;
    logic        hit;
    logic [19:0] epfn;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 20'h00010, 20'h00000, 1'b0, 20'h00000},  // R1 empty
    '{2'd1, 20'h00010, 20'hAAAAA, 1'b0, 20'h00000},
    '{2'd0, 20'h00010, 20'h00000, 1'b1, 20'hAAAAA},  // R2 R4
    '{2'd0, 20'h00011, 20'h00000, 1'b0, 20'h00000},  // R2 miss
    '{2'd1, 20'h00011, 20'h12345, 1'b0, 20'h00000},
    '{2'd0, 20'h00011, 20'h00000, 1'b1, 20'h12345},  // R4
    '{2'd1, 20'h00010, 20'h55555, 1'b0, 20'h00000},
    '{2'd0, 20'h00010, 20'h00000, 1'b1, 20'h55555},  // R5 in place
    '{2'd3, 20'h00010, 20'h00000, 1'b0, 20'h00000},  // R3
    '{2'd2, 20'h00000, 20'h00000, 1'b0, 20'h00000},
    '{2'd0, 20'h00010, 20'h00000, 1'b0, 20'h00000},  // R8
    '{2'd0, 20'h00011, 20'h00000, 1'b0, 20'h00000},  // R8
    '{2'd1, 20'hFFFFF, 20'h00001, 1'b0, 20'h00000},
    '{2'd0, 20'hFFFFF, 20'h00000, 1'b1, 20'h00001},  // R4 top page
    '{2'd0, 20'h00000, 20'h00000, 1'b0, 20'h00000}   // R2 miss
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] lfsr;
    // R1: reset state
    lkp_valid_i = 1'b1; lkp_vpn_i = 20'h0;
    #12;
    check(!lkp_hit_o, "R1 in reset", {20'h0, lkp_hit_o}, 21'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    #2;
    check(!lkp_hit_o && lkp_pfn_o == '0, "R1 after reset",
          {lkp_hit_o, lkp_pfn_o}, 21'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      lkp_valid_i  = (VEC[i].op == 2'd0);
      lkp_vpn_i    = VEC[i].vpn;
      fill_valid_i = (VEC[i].op == 2'd1);
      fill_vpn_i   = VEC[i].vpn;
      fill_pfn_i   = VEC[i].pfn;
      flush_i      = (VEC[i].op == 2'd2);
      #2;
      if (VEC[i].op == 2'd0 || VEC[i].op == 2'd3)
        check(lkp_hit_o == VEC[i].hit && lkp_pfn_o == VEC[i].epfn,
              $sformatf("R2/R3 vector %0d", i),
              {lkp_hit_o, lkp_pfn_o}, {VEC[i].hit, VEC[i].epfn});
    end

    // R9: flush beats a same-cycle fill
    op_flush();
    op_fill(20'h00042, 20'h0BEEF);
    @(negedge clk_i);
    fill_valid_i = 1'b1; fill_vpn_i = 20'h00077; fill_pfn_i = 20'h0CAFE;
    flush_i = 1'b1; lkp_valid_i = 1'b0;
    m_cnt = 0;
    op_look(20'h00077, "R9 fill dropped");
    op_look(20'h00042, "R9 older entry cleared");

    // R10 R6: fill to capacity, all retained
    op_flush();
    for (int i = 0; i < N; i++) op_fill(20'h00100 + 20'(i), 20'h80000 + 20'(i));
    for (int i = N - 1; i >= 0; i--) op_look(20'h00100 + 20'(i), "R10 capacity");

    // R7: lookups reorder; oldest now 0x11F
    op_look(20'h0011F, "R7 refresh hit");
    op_fill(20'h00200, 20'h0D00D);
    op_look(20'h0011E, "R7 LRU evicted");
    op_look(20'h0011F, "R7 refreshed kept");
    op_look(20'h00200, "R7 new entry");
    op_fill(20'h00105, 20'h0F00F);
    op_fill(20'h00300, 20'h01111);
    op_look(20'h0011D, "R7 next LRU evicted");
    op_look(20'h00105, "R5 R7 update promoted");

    // long mixed run against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[15:9] == 7'd0) op_flush();
      else if (lfsr[1:0] == 2'd2)
        op_fill(20'h00400 + 20'(lfsr[8:2] % 7'd44), {4'h5, lfsr});
      else op_look(20'h00400 + 20'(lfsr[8:2] % 7'd44), "R7 mixed run");
    end
    op_idle();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule